// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This block keeps the small set of 32-bit machine-mode control and status registers a simple in-order core needs, and it is the single place where traps are taken. The decode stage hands it a CSR instruction: the funct3 field, the 12-bit CSR address, the rs1 register index and the rs1 operand. The block answers in the same cycle with the old register value for rd and the next PC. If the address is not one of the six it implements, or the funct3 field does not name a CSR operation, it raises an illegal-instruction trap instead. The trap has no side effect on rd or on any CSR except the trap registers.

The load/store unit and the decoder raise synchronous exceptions on a separate request port. Each request carries an interrupt flag, a cause code and, for address faults and bad jump targets, the faulting value. When an exception is taken, the block records the cause and the faulting PC and saves the interrupt-enable bit. It redirects the PC to a fixed trap vector. The bad-value register changes only when the request actually carries a value. All outputs are combinational from the current request. Register updates become visible on the following clock edge.

Top module: `mtrap_csr_unit`

## Requirements
- R1: The implemented CSR addresses are 0x300 (status), 0x301 (ISA), 0x340 (scratch), 0x341 (exception PC), 0x342 (cause) and 0x343 (bad value). A CSR request to any other address raises `illegal_insn`.
- R2: An illegal CSR request deasserts `rd_we`, changes no CSR except the trap registers, and takes a trap with cause 2 and interrupt bit 0. The exception PC register receives `csr_pc`, the bad-value register keeps its value, and `pc_next` is the trap vector.
- R3: funct3 values 1 and 5 always write. Values 2, 3, 6 and 7 write only when `csr_rs1` is nonzero. Values 5, 6 and 7 use `csr_rs1` zero-extended as the source instead of `csr_operand`.
- R4: funct3 low bits 01 replace the register with the source, 10 set the source bits, and 11 clear the source bits. The new value is (old & ~clear) | set, and `rd_data` carries the old value.
- R5: A legal CSR request asserts `rd_we` and `pc_update`, sets `pc_next` to `csr_pc` + 4, and leaves `trap_taken` low. The written value is readable from the next cycle on.
- R6: A taken trap pulses `trap_taken` and sets `pc_next` to the trap vector (default 0x100). The cause register is written with the interrupt flag in bit 31 and the code in its low bits. The exception PC register receives the faulting PC, status bit 7 receives the old status bit 3, and status bit 3 is cleared.
- R7: The bad-value register is loaded with `exc_value` only when `exc_has_value` is high. Any other trap leaves it unchanged.
- R8: After reset, the status register reads 0x1800 (bits 12:11 = 3). The ISA, scratch, exception PC, cause and bad-value registers all read 0.
- R9: When `exc_valid` and `csr_valid` are high in the same cycle, the exception is taken and the CSR request is discarded: no rd write, no CSR write, no illegal flag.
- R10: Only status bits 3, 7 and 12:11 hold state. All other status bits read as 0 whatever is written.
- R11: funct3 values 0 and 4 are not CSR operations and raise `illegal_insn` even for an implemented address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_valid | input | 1 | CSR instruction present this cycle |
| csr_funct3 | input | 3 | Operation field of the CSR instruction |
| csr_addr | input | 12 | CSR address |
| csr_rs1 | input | 5 | rs1 index, also the immediate for funct3 5..7 |
| csr_operand | input | 32 | Value of register rs1 |
| csr_pc | input | 32 | PC of the CSR instruction |
| exc_valid | input | 1 | Exception request |
| exc_intr | input | 1 | Request is an interrupt |
| exc_code | input | 4 | Exception cause code |
| exc_has_value | input | 1 | Request carries a faulting value |
| exc_value | input | 32 | Faulting address or jump target |
| exc_pc | input | 32 | PC of the faulting instruction |
| rd_we | output | 1 | Write `rd_data` to rd |
| rd_data | output | 32 | Old CSR value |
| illegal_insn | output | 1 | CSR request was illegal |
| trap_taken | output | 1 | A trap is taken this cycle |
| pc_update | output | 1 | `pc_next` is valid |
| pc_next | output | 32 | Next PC: PC + 4 or trap vector |

## Verification
The bench targets funct3 set and clear with rs1 equal to zero. A design that ignores the rs1 gate would still write, so a following read would show changed bits. It sends exceptions without a value and checks that the bad-value register keeps what an earlier fault stored. It drives an exception and a CSR write in the same cycle, where a design with the wrong priority would return an rd value and corrupt the scratch register. Illegal addresses and funct3 values 0 and 4 are checked for a cause-2 trap that leaves the target registers untouched. Status writes of all ones show whether reserved bits leak through.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

   localparam int NUM_CSR = 6;

   typedef enum logic [2:0] {
      IDX_STATUS  = 3'd0,
      IDX_ISA     = 3'd1,
      IDX_SCRATCH = 3'd2,
      IDX_EPC     = 3'd3,
      IDX_CAUSE   = 3'd4,
      IDX_TVAL    = 3'd5
   } csr_idx_e;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_WRITE = 2'd1,
      OP_SET   = 2'd2,
      OP_CLEAR = 2'd3
   } csr_op_e;

   localparam int ILLEGAL_CAUSE = 2;
   localparam int ST_MIE        = 3;
   localparam int ST_MPIE       = 7;
   localparam int ST_MPP_LO     = 11;

   function automatic logic [11:0] csr_addr_of(input int idx);
      case (idx)
         0:       csr_addr_of = 12'h300;
         1:       csr_addr_of = 12'h301;
         2:       csr_addr_of = 12'h340;
         3:       csr_addr_of = 12'h341;
         4:       csr_addr_of = 12'h342;
         default: csr_addr_of = 12'h343;
      endcase
   endfunction

endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
   import mcsr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic                req_valid,
   input  logic [2:0]          funct3,
   input  logic [11:0]         addr,
   input  logic [4:0]          rs1_idx,
   input  logic [XLEN-1:0]     operand,
   output logic [NUM_CSR-1:0]  sel,
   output csr_op_e             op,
   output logic [XLEN-1:0]     src,
   output logic                wr_req,
   output logic                illegal
);

   logic hit;

   for (genvar g = 0; g < NUM_CSR; g++) begin : g_match
      assign sel[g] = (addr == csr_addr_of(g));
   end

   assign hit     = |sel;
   assign op      = csr_op_e'(funct3[1:0]);
   assign src     = funct3[2] ? {{(XLEN-5){1'b0}}, rs1_idx} : operand;
   assign illegal = req_valid & (!hit | (op == OP_NONE));
   assign wr_req  = req_valid & !illegal & ((op == OP_WRITE) | (rs1_idx != 5'd0));

   always_comb begin
      if (wr_req) begin
         assert_write_needs_hit_R1: assert (hit);
      end
   end

endmodule

// File: rtl/mcsr_rmw.sv
module mcsr_rmw
   import mcsr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  csr_op_e          op,
   input  logic [XLEN-1:0]  old_val,
   input  logic [XLEN-1:0]  src,
   output logic [XLEN-1:0]  new_val
);

   logic [XLEN-1:0] set_bits;
   logic [XLEN-1:0] clr_bits;

   always_comb begin
      set_bits = '0;
      clr_bits = '0;
      case (op)
         OP_WRITE: begin set_bits = src; clr_bits = '1; end
         OP_SET:   set_bits = src;
         OP_CLEAR: clr_bits = src;
         default:  ;
      endcase
      new_val = (old_val & ~clr_bits) | set_bits;
      if (op == OP_SET) begin
         assert_set_keeps_src_R4: assert ((new_val & src) == src);
      end
   end

endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
   import mcsr_pkg::*;
#(
   parameter int              XLEN          = 32,
   parameter int              CAUSE_W       = 4,
   parameter bit              MISA_WRITABLE = 1'b1,
   parameter logic [XLEN-1:0] MISA_RESET    = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CSR-1:0]  sel,
   input  logic                csr_we,
   input  logic [XLEN-1:0]     wdata,
   input  logic                trap_we,
   input  logic                trap_intr,
   input  logic [CAUSE_W-1:0]  trap_code,
   input  logic [XLEN-1:0]     trap_pc,
   input  logic                tval_we,
   input  logic [XLEN-1:0]     tval_val,
   output logic [XLEN-1:0]     rdata
);

   logic            st_mie;
   logic            st_mpie;
   logic [1:0]      st_mpp;
   logic [XLEN-1:0] isa_q;
   logic [XLEN-1:0] scratch_q;
   logic [XLEN-1:0] epc_q;
   logic [XLEN-1:0] cause_q;
   logic [XLEN-1:0] tval_q;
   logic [XLEN-1:0] status_v;
   logic [XLEN-1:0] vals [NUM_CSR];

   always_comb begin
      status_v                       = '0;
      status_v[ST_MIE]               = st_mie;
      status_v[ST_MPIE]              = st_mpie;
      status_v[ST_MPP_LO+1:ST_MPP_LO] = st_mpp;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_mie    <= 1'b0;
         st_mpie   <= 1'b0;
         st_mpp    <= 2'd3;
         scratch_q <= '0;
         epc_q     <= '0;
         cause_q   <= '0;
         tval_q    <= '0;
      end else if (trap_we) begin
         st_mpie               <= st_mie;
         st_mie                <= 1'b0;
         epc_q                 <= trap_pc;
         cause_q               <= '0;
         cause_q[XLEN-1]       <= trap_intr;
         cause_q[CAUSE_W-1:0]  <= trap_code;
         if (tval_we) tval_q <= tval_val;
      end else if (csr_we) begin
         if (sel[IDX_STATUS]) begin
            st_mie  <= wdata[ST_MIE];
            st_mpie <= wdata[ST_MPIE];
            st_mpp  <= wdata[ST_MPP_LO+1:ST_MPP_LO];
         end
         if (sel[IDX_SCRATCH]) scratch_q <= wdata;
         if (sel[IDX_EPC])     epc_q     <= wdata;
         if (sel[IDX_CAUSE])   cause_q   <= wdata;
         if (sel[IDX_TVAL])    tval_q    <= wdata;
      end
   end

   if (MISA_WRITABLE) begin : g_isa_reg
      always_ff @(posedge clk) begin
         if (!rst_n)                                  isa_q <= MISA_RESET;
         else if (!trap_we && csr_we && sel[IDX_ISA]) isa_q <= wdata;
      end
   end else begin : g_isa_const
      assign isa_q = MISA_RESET;
   end

   assign vals[IDX_STATUS]  = status_v;
   assign vals[IDX_ISA]     = isa_q;
   assign vals[IDX_SCRATCH] = scratch_q;
   assign vals[IDX_EPC]     = epc_q;
   assign vals[IDX_CAUSE]   = cause_q;
   assign vals[IDX_TVAL]    = tval_q;

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CSR; i++) begin
         if (sel[i]) rdata = rdata | vals[i];
      end
   end

   assert_trap_clears_mie_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_we |=> !st_mie);
   assert_trap_saves_mie_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_we |=> (st_mpie == $past(st_mie)));
   assert_tval_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!(trap_we && tval_we) && !(csr_we && !trap_we && sel[IDX_TVAL])) |=> $stable(tval_q));
   assert_scratch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(csr_we && sel[IDX_SCRATCH]) |=> $stable(scratch_q));

endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit
   import mcsr_pkg::*;
#(
   parameter int              XLEN          = 32,
   parameter int              CAUSE_W       = 4,
   parameter logic [XLEN-1:0] TRAP_VEC      = 32'h0000_0100,
   parameter bit              MISA_WRITABLE = 1'b1,
   parameter logic [XLEN-1:0] MISA_RESET    = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                csr_valid,
   input  logic [2:0]          csr_funct3,
   input  logic [11:0]         csr_addr,
   input  logic [4:0]          csr_rs1,
   input  logic [XLEN-1:0]     csr_operand,
   input  logic [XLEN-1:0]     csr_pc,
   input  logic                exc_valid,
   input  logic                exc_intr,
   input  logic [CAUSE_W-1:0]  exc_code,
   input  logic                exc_has_value,
   input  logic [XLEN-1:0]     exc_value,
   input  logic [XLEN-1:0]     exc_pc,
   output logic                rd_we,
   output logic [XLEN-1:0]     rd_data,
   output logic                illegal_insn,
   output logic                trap_taken,
   output logic                pc_update,
   output logic [XLEN-1:0]     pc_next
);

   localparam int PC_STEP = 4;

   if (XLEN < 32) begin : g_bad_xlen
      $error("mtrap_csr_unit: XLEN must be at least 32");
   end
   if (CAUSE_W < 2 || CAUSE_W > XLEN - 1) begin : g_bad_cause
      $error("mtrap_csr_unit: CAUSE_W out of range");
   end
   if (TRAP_VEC[1:0] != 2'b00) begin : g_bad_vec
      $error("mtrap_csr_unit: TRAP_VEC must be word aligned");
   end

   logic [NUM_CSR-1:0] sel;
   csr_op_e            op;
   logic [XLEN-1:0]    src;
   logic               dec_wr;
   logic               dec_illegal;
   logic [XLEN-1:0]    old_val;
   logic [XLEN-1:0]    new_val;
   logic               csr_we_int;
   logic               trap_we;
   logic               tval_we;
   logic [CAUSE_W-1:0] trap_code;
   logic [XLEN-1:0]    trap_pc;

   mcsr_decode #(.XLEN(XLEN)) u_decode (
      .req_valid (csr_valid),
      .funct3    (csr_funct3),
      .addr      (csr_addr),
      .rs1_idx   (csr_rs1),
      .operand   (csr_operand),
      .sel       (sel),
      .op        (op),
      .src       (src),
      .wr_req    (dec_wr),
      .illegal   (dec_illegal)
   );

   mcsr_rmw #(.XLEN(XLEN)) u_rmw (
      .op      (op),
      .old_val (old_val),
      .src     (src),
      .new_val (new_val)
   );

   // exception port has priority over a CSR request in the same cycle
   assign illegal_insn = dec_illegal & !exc_valid;
   assign trap_we      = exc_valid | illegal_insn;
   assign tval_we      = exc_valid & exc_has_value;
   assign trap_code    = exc_valid ? exc_code : CAUSE_W'(ILLEGAL_CAUSE);
   assign trap_pc      = exc_valid ? exc_pc : csr_pc;
   assign csr_we_int   = dec_wr & !exc_valid;

   mcsr_file #(
      .XLEN          (XLEN),
      .CAUSE_W       (CAUSE_W),
      .MISA_WRITABLE (MISA_WRITABLE),
      .MISA_RESET    (MISA_RESET)
   ) u_file (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .csr_we    (csr_we_int),
      .wdata     (new_val),
      .trap_we   (trap_we),
      .trap_intr (exc_valid & exc_intr),
      .trap_code (trap_code),
      .trap_pc   (trap_pc),
      .tval_we   (tval_we),
      .tval_val  (exc_value),
      .rdata     (old_val)
   );

   assign rd_we      = csr_valid & !dec_illegal & !exc_valid;
   assign rd_data    = rd_we ? old_val : '0;
   assign trap_taken = trap_we;
   assign pc_update  = rd_we | trap_we;
   assign pc_next    = trap_we ? TRAP_VEC : csr_pc + XLEN'(PC_STEP);

   assert_exc_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (!rd_we && !illegal_insn && !csr_we_int));
   assert_illegal_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_insn |-> (!rd_we && !csr_we_int && !tval_we && trap_taken));
   assert_trap_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_taken |-> (pc_next == TRAP_VEC && pc_update));
   assert_legal_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> (pc_next == csr_pc + XLEN'(PC_STEP) && !trap_taken));

endmodule

// File: tb/test_mtrap_csr_unit.sv
module test_mtrap_csr_unit;

   localparam logic [31:0] VEC = 32'h0000_0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_valid = 1'b0;
   logic [2:0]  csr_funct3 = '0;
   logic [11:0] csr_addr = '0;
   logic [4:0]  csr_rs1 = '0;
   logic [31:0] csr_operand = '0;
   logic [31:0] csr_pc = '0;
   logic        exc_valid = 1'b0;
   logic        exc_intr = 1'b0;
   logic [3:0]  exc_code = '0;
   logic        exc_has_value = 1'b0;
   logic [31:0] exc_value = '0;
   logic [31:0] exc_pc = '0;
   logic        rd_we;
   logic [31:0] rd_data;
   logic        illegal_insn;
   logic        trap_taken;
   logic        pc_update;
   logic [31:0] pc_next;

   int total = 0;
   int bad = 0;

   // reference state
   logic [31:0] m_status, m_isa, m_scratch, m_epc, m_cause, m_tval;

   mtrap_csr_unit i_mtrap_csr_unit (
      .clk, .rst_n, .csr_valid, .csr_funct3, .csr_addr, .csr_rs1, .csr_operand,
      .csr_pc, .exc_valid, .exc_intr, .exc_code, .exc_has_value, .exc_value,
      .exc_pc, .rd_we, .rd_data, .illegal_insn, .trap_taken, .pc_update, .pc_next
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [32:0] model_read(input logic [11:0] a);
      case (a)
         12'h300: model_read = {1'b1, m_status};
         12'h301: model_read = {1'b1, m_isa};
         12'h340: model_read = {1'b1, m_scratch};
         12'h341: model_read = {1'b1, m_epc};
         12'h342: model_read = {1'b1, m_cause};
         12'h343: model_read = {1'b1, m_tval};
         default: model_read = {1'b0, 32'h0};
      endcase
   endfunction

   task automatic model_write(input logic [11:0] a, input logic [31:0] v);
      case (a)
         12'h300: m_status  = v & 32'h0000_1888;
         12'h301: m_isa     = v;
         12'h340: m_scratch = v;
         12'h341: m_epc     = v;
         12'h342: m_cause   = v;
         12'h343: m_tval    = v;
         default: ;
      endcase
   endtask

   task automatic model_trap(input logic intr, input logic [3:0] code, input logic [31:0] pc,
                             input logic hasv, input logic [31:0] val);
      m_status[7] = m_status[3];
      m_status[3] = 1'b0;
      m_cause     = {intr, 27'b0, code};
      m_epc       = pc;
      if (hasv) m_tval = val;
   endtask

   task automatic do_csr(input string req, input logic [2:0] f3, input logic [11:0] a,
                         input logic [4:0] rs1, input logic [31:0] opnd,
                         input logic [31:0] pc);
      logic [32:0] r;
      logic        legal, we;
      logic [31:0] src, nv;
      @(negedge clk);
      csr_valid = 1'b1; csr_funct3 = f3; csr_addr = a; csr_rs1 = rs1;
      csr_operand = opnd; csr_pc = pc;
      #4;
      r     = model_read(a);
      legal = r[32] && (f3[1:0] != 2'b00);
      src   = f3[2] ? {27'b0, rs1} : opnd;
      we    = (f3[1:0] == 2'b01) || (rs1 != 5'd0);
      case (f3[1:0])
         2'b01:   nv = src;
         2'b10:   nv = r[31:0] | src;
         default: nv = r[31:0] & ~src;
      endcase
      chk(req, "illegal_insn", {31'b0, illegal_insn}, {31'b0, !legal});
      chk(req, "rd_we", {31'b0, rd_we}, {31'b0, legal});
      chk(req, "trap_taken", {31'b0, trap_taken}, {31'b0, !legal});
      if (legal) begin
         chk(req, "rd_data", rd_data, r[31:0]);
         chk(req, "pc_next", pc_next, pc + 32'd4);
         if (we) model_write(a, nv);
      end else begin
         chk(req, "pc_next", pc_next, VEC);
         model_trap(1'b0, 4'd2, pc, 1'b0, 32'h0);
      end
      @(posedge clk);
      #1 csr_valid = 1'b0;
   endtask

   task automatic do_exc(input string req, input logic intr, input logic [3:0] code,
                         input logic hasv, input logic [31:0] val, input logic [31:0] pc,
                         input logic with_csr);
      @(negedge clk);
      exc_valid = 1'b1; exc_intr = intr; exc_code = code; exc_has_value = hasv;
      exc_value = val; exc_pc = pc;
      csr_valid = with_csr; csr_funct3 = 3'd1; csr_addr = 12'h340; csr_rs1 = 5'd3;
      csr_operand = 32'hDEAD_0000; csr_pc = pc;
      #4;
      chk(req, "trap_taken", {31'b0, trap_taken}, 32'd1);
      chk(req, "pc_next", pc_next, VEC);
      chk(req, "rd_we", {31'b0, rd_we}, 32'd0);
      chk(req, "illegal_insn", {31'b0, illegal_insn}, 32'd0);
      model_trap(intr, code, pc, hasv, val);
      @(posedge clk);
      #1 exc_valid = 1'b0; csr_valid = 1'b0;
   endtask

   task automatic read_all(input string req);
      logic [11:0] addrs [6] = '{12'h300, 12'h301, 12'h340, 12'h341, 12'h342, 12'h343};
      for (int i = 0; i < 6; i++) do_csr(req, 3'd2, addrs[i], 5'd0, 32'hFFFF_FFFF, 32'h40);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [11:0] pool [8] = '{12'h300, 12'h301, 12'h340, 12'h341, 12'h342, 12'h343,
                                12'h344, 12'hF11};
      logic [3:0]  codes [4] = '{4'd0, 4'd4, 4'd5, 4'd6};
      void'($urandom(32'd7321));
      m_status = 32'h0000_1800; m_isa = '0; m_scratch = '0;
      m_epc = '0; m_cause = '0; m_tval = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R8: reset values through reads with rs1 = 0
      read_all("R8");
      // R10: reserved status bits stay zero
      do_csr("R10", 3'd1, 12'h300, 5'd1, 32'hFFFF_FFFF, 32'h80);
      do_csr("R10", 3'd2, 12'h300, 5'd0, 32'h0, 32'h84);
      // R3: set / clear with rs1 = 0 write nothing
      do_csr("R3", 3'd1, 12'h340, 5'd2, 32'hA5A5_5A5A, 32'h88);
      do_csr("R3", 3'd3, 12'h340, 5'd0, 32'hFFFF_FFFF, 32'h8C);
      do_csr("R3", 3'd7, 12'h340, 5'd0, 32'h0, 32'h90);
      do_csr("R3", 3'd2, 12'h340, 5'd0, 32'h0, 32'h94);
      // R4: immediate set and clear
      do_csr("R4", 3'd6, 12'h340, 5'd5, 32'h0, 32'h98);
      do_csr("R4", 3'd7, 12'h340, 5'd18, 32'h0, 32'h9C);
      do_csr("R4", 3'd5, 12'h301, 5'd31, 32'h0, 32'hA0);
      // R6 / R7: exception with a value, then one without
      do_csr("R6", 3'd2, 12'h300, 5'd8, 32'h0000_0008, 32'hA4);
      do_exc("R7", 1'b0, 4'd4, 1'b1, 32'h0000_1003, 32'h200, 1'b0);
      read_all("R6");
      do_exc("R7", 1'b1, 4'd5, 1'b0, 32'h0BAD_0BAD, 32'h204, 1'b0);
      read_all("R7");
      // R1 / R2: unmapped address
      do_csr("R1", 3'd1, 12'h7C0, 5'd4, 32'h1234_5678, 32'h300);
      read_all("R2");
      // R11: funct3 0 and 4 on implemented address
      do_csr("R11", 3'd0, 12'h340, 5'd4, 32'h1111_1111, 32'h304);
      do_csr("R11", 3'd4, 12'h340, 5'd4, 32'h2222_2222, 32'h308);
      read_all("R11");
      // R9: exception and CSR write together
      do_exc("R9", 1'b0, 4'd6, 1'b1, 32'h0000_2002, 32'h400, 1'b1);
      read_all("R9");
      // R5: random mix, legal requests advance the PC
      for (int n = 0; n < 400; n++) begin
         logic [31:0] rv;
         rv = $urandom;
         if (rv[2:0] == 3'd0)
            do_exc("R6", rv[3], codes[rv[5:4]], rv[6], $urandom, {$urandom} & 32'hFFFF_FFFC,
                   rv[7]);
         else
            do_csr("R5", rv[10:8], pool[rv[13:11]], (rv[14] ? 5'd0 : rv[19:15]), $urandom,
                   {$urandom} & 32'hFFFF_FFFC);
      end
      read_all("R4");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule